// File: doc/BRIEF.md
# Binary-Template Cellular Array Processor

This block is a small two-dimensional array of black-and-white pixel cells that applies a 3x3 neighbourhood rule with one-bit weights. Each cell holds a single pixel. Nine coupling bits mark which positions of the 3x3 window take part: the eight neighbours, plus the cell itself at the centre. One bias bit selects a threshold of 0.5 or 1.5. A cell counts the marked window positions that hold a black pixel. It turns black when that count is above the threshold, and white otherwise. Positions that fall outside the array read a shared border pixel.

Two evaluation modes exist. In the snapshot mode, every cell updates once and all cells update together, from the pixel values held before the update. In the propagating mode, the same update repeats once per clock. Each new result feeds the next step, so black regions spread until nothing changes. A step limit stops patterns that oscillate.

Each cell has a mask with an enable bit and a stored value. A masked cell takes the stored value during evaluation, or its inverse when a global invert bit is set. This supports fixed state maps and logic operations between images. Images and masks are written one row per cycle, and the current image is read one row at a time. Two presets fill the array with all white or all black.

Top module: `bwca_array`

## Requirements
- R1: A pixel value of 0 means black and 1 means white. Reset makes every pixel white, clears every mask enable, and drives busy and done low. row_rdata bit c always shows the pixel in column c of row row_addr. While idle, row_wr stores row_wdata into row row_addr at the next edge.
- R2: While idle, preset_white makes every pixel 1 at the next edge, and preset_black makes every pixel 0. When both are asserted, white wins. A preset takes precedence over row and mask writes and over start in the same cycle.
- R3: Coupling bit k = 3*(dr+1) + (dc+1) covers the window position at row offset dr and column offset dc, each in {-1, 0, +1}. Offset -1 is the lower row or column index, and bit 4 is the cell itself. D is the number of set coupling bits whose covered pixel is 0.
- R4: With bias_hi = 0, a cell's step result is 0 when D >= 1. With bias_hi = 1, it is 0 when D >= 2. Otherwise the result is 1.
- R5: A window position outside the array reads border_val.
- R6: A start with a_mode = 0, accepted while idle, applies exactly one step to all cells at that edge, using the pixel values from before the edge. done is high in the cycle after that edge, and busy stays low.
- R7: A start with a_mode = 1 applies one step at the accepting edge and one more step at every following edge. Each step uses the results of the previous one. The run ends at the first step that changes no pixel, and done is high in the cycle after that edge.
- R8: A propagating run applies at most MAX_ITER steps (default 16). If pixels are still changing at that point, the run ends after step MAX_ITER and done follows as in R7.
- R9: While idle, mask_wr sets, for row row_addr, the mask enable bits to mask_row_en and the stored values to row_wdata. During every step, a cell whose mask is enabled takes its stored value XOR mask_inv, and neighbours see that forced value in the following steps.
- R10: done is a pulse one cycle wide, and it is never high while busy is high.
- R11: While busy is high, row_wr, mask_wr, preset_white, preset_black and start have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_addr | input | $clog2(ROWS) | Row selected for read, write and mask write |
| row_wr | input | 1 | Write row_wdata into the selected pixel row |
| row_wdata | input | COLS | Row data for pixel and mask writes |
| row_rdata | output | COLS | Pixels of the selected row |
| mask_wr | input | 1 | Write the selected row's mask |
| mask_row_en | input | COLS | Mask enable bits for the row being written |
| mask_inv | input | 1 | Force masked cells to the inverse of their stored value |
| preset_white | input | 1 | Fill all pixels with 1 |
| preset_black | input | 1 | Fill all pixels with 0 |
| tmpl_terms | input | 9 | Coupling bits of the 3x3 window |
| bias_hi | input | 1 | Threshold select: 0 for 0.5, 1 for 1.5 |
| a_mode | input | 1 | 1 selects propagating mode, 0 selects snapshot mode |
| border_val | input | 1 | Pixel value seen outside the array |
| start | input | 1 | Begin an evaluation |
| busy | output | 1 | A propagating run is in progress |
| done | output | 1 | One-cycle pulse when an evaluation ends |

## Verification
The hardest condition to reach from the ports is the step limit. The threshold rule is monotone and most patterns settle within a few steps, so the run must be made to oscillate on purpose. The bench sets only the left and right coupling bits with a white border and loads an alternating row. That row swaps phase on every step, so the run has to end on the limit, and the final image must equal the loaded one. During that long run, the bench also issues a preset and a row write to show that commands are ignored while busy. Around this directed case, the bench sweeps every coupling pattern with both biases and both border values in snapshot mode. It then drives many pseudo-random propagating runs with masks, comparing each against an arithmetic model of the step.

// File: rtl/bwca_pkg.sv
package bwca_pkg;
    // Window taps: index = 3*(row offset + 1) + (column offset + 1)
    localparam int unsigned TAPS   = 9;
    localparam int unsigned CENTRE = 4;
    localparam int unsigned CNT_W  = 4;

    typedef logic [TAPS-1:0] tmpl_t;
endpackage

// File: rtl/bwca_window.sv
module bwca_window #(
    parameter int ROWS = 4,
    parameter int COLS = 4
) (
    input  logic [ROWS*COLS-1:0]                 pix,
    input  logic                                 border_val,
    output logic [ROWS*COLS*bwca_pkg::TAPS-1:0]  win
);
    import bwca_pkg::*;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            for (genvar t = 0; t < TAPS; t++) begin : g_tap
                localparam int RR  = r + (t / 3) - 1;
                localparam int CC  = c + (t % 3) - 1;
                localparam int IDX = (r * COLS + c) * TAPS + t;
                if (RR >= 0 && RR < ROWS && CC >= 0 && CC < COLS) begin : g_in
                    assign win[IDX] = pix[RR * COLS + CC];
                end else begin : g_edge
                    assign win[IDX] = border_val;
                end
            end
        end
    end
endmodule

// File: rtl/bwca_cell.sv
module bwca_cell (
    input  bwca_pkg::tmpl_t win,
    input  bwca_pkg::tmpl_t terms,
    input  logic            bias_hi,
    input  logic            mask_en,
    input  logic            mask_val,
    input  logic            mask_inv,
    output logic            nxt
);
    import bwca_pkg::*;

    logic [CNT_W-1:0] black_cnt;
    logic             goes_black;

    always_comb begin
        black_cnt = '0;
        for (int k = 0; k < TAPS; k++) begin
            black_cnt = black_cnt + CNT_W'(terms[k] & ~win[k]);
        end
    end

    assign goes_black = bias_hi ? (black_cnt >= CNT_W'(2)) : (black_cnt >= CNT_W'(1));
    assign nxt        = mask_en ? (mask_val ^ mask_inv) : ~goes_black;
endmodule

// File: rtl/bwca_array.sv
module bwca_array #(
    parameter int ROWS     = 4,
    parameter int COLS     = 4,
    parameter int MAX_ITER = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(ROWS)-1:0]  row_addr,
    input  logic                     row_wr,
    input  logic [COLS-1:0]          row_wdata,
    output logic [COLS-1:0]          row_rdata,
    input  logic                     mask_wr,
    input  logic [COLS-1:0]          mask_row_en,
    input  logic                     mask_inv,
    input  logic                     preset_white,
    input  logic                     preset_black,
    input  logic [8:0]               tmpl_terms,
    input  logic                     bias_hi,
    input  logic                     a_mode,
    input  logic                     border_val,
    input  logic                     start,
    output logic                     busy,
    output logic                     done
);
    import bwca_pkg::*;

    localparam int N  = ROWS * COLS;
    localparam int CW = $clog2(MAX_ITER + 1);

    typedef struct packed {
        logic [N-1:0]  pix;
        logic [N-1:0]  men;
        logic [N-1:0]  mval;
        logic          busy;
        logic          done;
        logic [CW-1:0] iter;
    } st_t;

    st_t st_q, st_d;

    logic [N*TAPS-1:0] win;
    logic [N-1:0]      step_pix;
    logic              changed;
    logic              start_ok;
    logic [CW-1:0]     cnt_nxt;

    bwca_window #(.ROWS(ROWS), .COLS(COLS)) u_window (
        .pix        (st_q.pix),
        .border_val (border_val),
        .win        (win)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        bwca_cell u_cell (
            .win      (win[i*TAPS +: TAPS]),
            .terms    (tmpl_terms),
            .bias_hi  (bias_hi),
            .mask_en  (st_q.men[i]),
            .mask_val (st_q.mval[i]),
            .mask_inv (mask_inv),
            .nxt      (step_pix[i])
        );
    end

    assign changed  = (step_pix != st_q.pix);
    assign start_ok = !st_q.busy && start && !preset_white && !preset_black
                      && !row_wr && !mask_wr;
    assign cnt_nxt  = st_q.iter + CW'(1);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            st_d.pix  = step_pix;
            st_d.iter = cnt_nxt;
            if (!changed || cnt_nxt == CW'(MAX_ITER)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (preset_white) begin
            st_d.pix = '1;
        end else if (preset_black) begin
            st_d.pix = '0;
        end else if (row_wr || mask_wr) begin
            if (row_wr) begin
                st_d.pix[int'(row_addr)*COLS +: COLS] = row_wdata;
            end
            if (mask_wr) begin
                st_d.men[int'(row_addr)*COLS +: COLS]  = mask_row_en;
                st_d.mval[int'(row_addr)*COLS +: COLS] = row_wdata;
            end
        end else if (start) begin
            st_d.pix  = step_pix;
            st_d.iter = CW'(1);
            if (!a_mode || !changed || MAX_ITER == 1) begin
                st_d.done = 1'b1;
            end else begin
                st_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pix <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_rdata = st_q.pix[int'(row_addr)*COLS +: COLS];
    assign busy      = st_q.busy;
    assign done      = st_q.done;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R10
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.busy);

    // R6
    snapshot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ok && !a_mode) |=> (st_q.done && !st_q.busy));

    // R8
    iter_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.iter <= CW'(MAX_ITER));

    // R2
    preset_white_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && preset_white) |=> (&st_q.pix));

    // R9
    mask_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy || start_ok) |=>
            ((st_q.pix & $past(st_q.men)) ==
             (($past(st_q.mval) ^ {N{$past(mask_inv)}}) & $past(st_q.men))));

    // R11
    busy_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> (st_q.busy || st_q.done));
endmodule

// File: tb/bwca_array_tb.sv
module bwca_array_tb;
    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int N    = 16;
    localparam int MAXI = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    row_addr = '0;
    logic          row_wr = 1'b0;
    logic [3:0]    row_wdata = '0;
    logic [3:0]    row_rdata;
    logic          mask_wr = 1'b0;
    logic [3:0]    mask_row_en = '0;
    logic          mask_inv = 1'b0;
    logic          preset_white = 1'b0;
    logic          preset_black = 1'b0;
    logic [8:0]    tmpl_terms = '0;
    logic          bias_hi = 1'b0;
    logic          a_mode = 1'b0;
    logic          border_val = 1'b1;
    logic          start = 1'b0;
    logic          busy;
    logic          done;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bwca_array #(.ROWS(ROWS), .COLS(COLS), .MAX_ITER(MAXI)) u_dut (
        .clk, .rst_n, .row_addr, .row_wr, .row_wdata, .row_rdata,
        .mask_wr, .mask_row_en, .mask_inv, .preset_white, .preset_black,
        .tmpl_terms, .bias_hi, .a_mode, .border_val, .start, .busy, .done
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_step(input logic [15:0] p,
            input logic [8:0] t, input bit b, input bit bd,
            input logic [15:0] me, input logic [15:0] mv, input bit inv);
        logic [15:0] n;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                int d = 0;
                bit px;
                for (int tr = 0; tr < 3; tr++) begin
                    for (int tc = 0; tc < 3; tc++) begin
                        int rr = r + tr - 1;
                        int cc = c + tc - 1;
                        if (rr >= 0 && rr < ROWS && cc >= 0 && cc < COLS) px = p[rr*COLS+cc];
                        else px = bd;
                        if (t[tr*3+tc] && !px) d++;
                    end
                end
                if (me[r*COLS+c]) n[r*COLS+c] = mv[r*COLS+c] ^ inv;
                else n[r*COLS+c] = b ? !(d >= 2) : !(d >= 1);
            end
        end
        return n;
    endfunction

    task automatic load_img(input logic [15:0] img);
        for (int r = 0; r < ROWS; r++) begin
            @(negedge clk);
            row_addr = 2'(r); row_wdata = img[r*COLS +: COLS]; row_wr = 1'b1;
        end
        @(negedge clk);
        row_wr = 1'b0;
    endtask

    task automatic load_mask(input logic [15:0] en, input logic [15:0] val);
        for (int r = 0; r < ROWS; r++) begin
            @(negedge clk);
            row_addr = 2'(r); row_wdata = val[r*COLS +: COLS];
            mask_row_en = en[r*COLS +: COLS]; mask_wr = 1'b1;
        end
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    task automatic read_img(output logic [15:0] img);
        for (int r = 0; r < ROWS; r++) begin
            row_addr = 2'(r);
            #1;
            img[r*COLS +: COLS] = row_rdata;
        end
    endtask

    // returns number of edges from the accepting edge until done is seen
    task automatic run_eval(output int n);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic model_run(input logic [15:0] p0, input logic [8:0] t, input bit b,
            input bit bd, input bit am, input logic [15:0] me, input logic [15:0] mv,
            input bit inv, output logic [15:0] pf, output int steps);
        logic [15:0] cur = p0;
        logic [15:0] nx;
        steps = 0;
        forever begin
            nx = model_step(cur, t, b, bd, me, mv, inv);
            steps++;
            if (!am || nx == cur || steps == MAXI) begin
                cur = nx;
                break;
            end
            cur = nx;
        end
        pf = cur;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] img, exp_img, me, mv;
        logic [15:0] imgs [3];
        int n, exp_n;
        imgs[0] = 16'hA5C3; imgs[1] = 16'hFBFF; imgs[2] = 16'h0F70;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_img(img);
        chk(img == 16'hFFFF, "R1 reset pixels white", 32'(img), 32'hFFFF);
        chk(!busy && !done, "R1 reset busy/done low", {busy, done}, 0);

        // R1 row write/read
        load_img(16'h1234);
        read_img(img);
        chk(img == 16'h1234, "R1 row write readback", 32'(img), 32'h1234);

        // R2 presets and priority
        @(negedge clk); preset_black = 1'b1;
        @(negedge clk); preset_black = 1'b0;
        read_img(img);
        chk(img == 16'h0000, "R2 preset black", 32'(img), 0);
        @(negedge clk); preset_black = 1'b1; preset_white = 1'b1;
        @(negedge clk); preset_black = 1'b0; preset_white = 1'b0;
        read_img(img);
        chk(img == 16'hFFFF, "R2 white wins over black", 32'(img), 32'hFFFF);

        // R3 R4 R5 R6: sweep all templates, both biases, in snapshot mode
        load_mask(16'h0000, 16'h0000);
        a_mode = 1'b0;
        for (int t = 0; t < 512; t++) begin
            for (int b = 0; b < 2; b++) begin
                int k = (t + b) % 3;
                tmpl_terms = 9'(t); bias_hi = b[0]; border_val = t[0] ^ t[4] ^ b[0];
                load_img(imgs[k]);
                exp_img = model_step(imgs[k], 9'(t), b[0], border_val, '0, '0, 1'b0);
                run_eval(n);
                chk(n == 1, "R6 snapshot done after one edge", 32'(n), 1);
                read_img(img);
                chk(img == exp_img, "R3/R4/R5 snapshot step", 32'(img), 32'(exp_img));
            end
        end

        // R7 R9: pseudo-random propagating runs with masks
        a_mode = 1'b1;
        for (int i = 0; i < 300; i++) begin
            logic [15:0] p0 = 16'($urandom);
            me = (i % 3 == 0) ? 16'h0000 : 16'($urandom) & 16'($urandom);
            mv = 16'($urandom);
            tmpl_terms = 9'($urandom); bias_hi = 1'($urandom);
            border_val = 1'($urandom); mask_inv = 1'($urandom);
            load_mask(me, mv);
            load_img(p0);
            model_run(p0, tmpl_terms, bias_hi, border_val, 1'b1, me, mv, mask_inv,
                      exp_img, exp_n);
            run_eval(n);
            chk(n == exp_n, "R7 propagating step count", 32'(n), 32'(exp_n));
            read_img(img);
            chk(img == exp_img, "R7/R9 propagating result", 32'(img), 32'(exp_img));
        end
        mask_inv = 1'b0;
        load_mask(16'h0000, 16'h0000);

        // R9 directed: masked cells forced to inverse of stored value
        tmpl_terms = 9'b000010000; bias_hi = 1'b0; border_val = 1'b1; mask_inv = 1'b1;
        load_mask(16'h00F0, 16'h0050);
        load_img(16'hFFFF);
        run_eval(n);
        read_img(img);
        chk(img == 16'hFFAF, "R9 mask inverted force", 32'(img), 32'hFFAF);
        mask_inv = 1'b0;
        load_mask(16'h0000, 16'h0000);

        // R7 directed: shadow from one black corner along a diagonal
        tmpl_terms = 9'b000000100; bias_hi = 1'b0; border_val = 1'b1;
        load_img(16'hFFF7);
        model_run(16'hFFF7, tmpl_terms, 1'b0, 1'b1, 1'b1, '0, '0, 1'b0, exp_img, exp_n);
        run_eval(n);
        chk(n == exp_n, "R7 diagonal propagation count", 32'(n), 32'(exp_n));
        read_img(img);
        chk(img == exp_img, "R7 diagonal propagation image", 32'(img), 32'(exp_img));

        // R8 R11 R10: oscillating row hits the cap; commands during busy ignored
        tmpl_terms = 9'b000101000; bias_hi = 1'b0; border_val = 1'b1;
        load_img(16'hFFFA);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R7 busy during propagating run", 32'(busy), 1);
        preset_black = 1'b1; row_wr = 1'b1; row_addr = 2'd3; row_wdata = 4'h0;
        mask_wr = 1'b1; mask_row_en = 4'hF;
        @(negedge clk);
        preset_black = 1'b0; row_wr = 1'b0; mask_wr = 1'b0; mask_row_en = 4'h0;
        n = 2;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(n == MAXI, "R8 run stops at step cap", 32'(n), 32'(MAXI));
        chk(!busy, "R10 busy low with done", 32'(busy), 0);
        @(negedge clk);
        chk(!done, "R10 done one cycle wide", 32'(done), 0);
        read_img(img);
        chk(img == 16'hFFFA, "R11 commands ignored while busy", 32'(img), 32'hFFFA);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule